// File: doc/BRIEF.md
# Capture Buffer Read-Back Controller

This block sits between the sampling front end of a logic analyzer and the byte-wide path that carries the captured samples to a host. Once armed, it writes one sample per sample-enable pulse into an on-chip circular buffer and advances a write pointer. When the trigger arrives, capture continues for a programmed number of further samples. The block then leaves write mode and ignores all later input samples.

In read mode the same pointer runs backwards. The sample captured last is sent first, and older samples follow in descending address order. Each sample is offered on a valid/ready transmit port. `tx_valid` stays high with `tx_data` unchanged until the consumer raises `tx_ready`. Back-pressure may last any number of cycles. After each accepted sample the block spends one cycle fetching the next word from memory. The block then raises a done flag and waits in idle until it is armed again.

Top module: `capture_readback`

## Requirements
- R1: With `rst_n` low the block is idle, `done` and `tx_valid` are 0, and the write pointer and sample counter are cleared. A capture started after reset writes its first sample at address 0.
- R2: A one-cycle `arm` pulse while idle starts a capture, clears `done` and sets the write pointer to 0. `arm` pulses during a capture or a read-out are ignored and leave the pointer unchanged.
- R3: During capture, each cycle with `smp_en` high stores `smp_data` at the write pointer and then increments the pointer modulo `DEPTH`. Older samples are overwritten circularly.
- R4: `trig` is honoured only in the pre-trigger phase, and a sample with `smp_en` in the same cycle is still stored. After the trigger, exactly `delay_count` more samples are stored before read mode starts. With `delay_count` = 0, read mode starts right after the trigger cycle.
- R5: In read mode and in idle, `smp_en` has no effect and no sample is written.
- R6: The first sample sent is the one written last. Each following sample comes from the next lower address, wrapping modulo `DEPTH`.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` is held. After each accepted sample, `tx_valid` is low for exactly one cycle, which is the memory read latency.
- R8: Exactly `read_count` samples are sent. With `read_count` = 0, no sample is sent and `done` rises right after capture ends.
- R9: `done` rises in the cycle after the last sample is accepted and stays high, with `tx_valid` low, until the next accepted `arm`.
- R10: `delay_count` and `read_count` are latched when an `arm` is accepted. Later changes on those inputs do not affect the capture that is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start a capture (accepted only when idle) |
| trig | input | 1 | Trigger event from the external trigger logic |
| smp_en | input | 1 | Sample strobe |
| smp_data | input | DATA_W | Sample value |
| delay_count | input | CNT_W | Samples to store after the trigger |
| read_count | input | CNT_W | Samples to send during read-out |
| tx_data | output | DATA_W | Sample offered to the transmitter |
| tx_valid | output | 1 | `tx_data` holds a sample |
| tx_ready | input | 1 | Transmitter accepts the sample in this cycle |
| done | output | 1 | Read-out finished; block is idle |

## Verification
The assertions assume that the transmitter follows the valid/ready rules. They also assume that `arm` is a single-cycle pulse, so a re-arm on the cycle after `done` is taken as a new capture. Pointer checks assume that write and handshake strobes never overlap, which holds because capture and read-out are separate phases. The stimulus drives every input half a cycle away from the active edge and pulses `arm` for one cycle only. It drives `tx_ready` either constantly high or with a periodic stall pattern. It also raises `smp_en` with junk data during read-out, to show that stored samples are not disturbed.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRE   = 3'd1,
    ST_POST  = 3'd2,
    ST_FETCH = 3'd3,
    ST_SEND  = 3'd4
  } cap_state_t;
endpackage

// File: rtl/cap_ram.sv
module cap_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  // Registered read port: one cycle from address to data.
  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/cap_ptr.sv
module cap_ptr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          up,
  input  logic          down,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) ptr <= '0;
    else if (up)       ptr <= ptr + 1'b1;
    else if (down)     ptr <= ptr - 1'b1;
  end
endmodule

// File: rtl/cap_seq.sv
module cap_seq
  import cap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             trig,
  input  logic             smp_en,
  input  logic [CNT_W-1:0] delay_count,
  input  logic [CNT_W-1:0] read_count,
  input  logic             tx_ready,
  output cap_state_t       state,
  output logic             clr_ptr,
  output logic             wr_en,
  output logic             rd_en,
  output logic             step_dn,
  output logic             tx_valid,
  output logic             done
);
  logic [CNT_W-1:0] dly_q, rdn_q, cnt;
  logic [CNT_W-1:0] cnt_nxt;

  assign cnt_nxt  = cnt + 1'b1;
  assign clr_ptr  = (state == ST_IDLE) && arm;
  assign wr_en    = smp_en && ((state == ST_PRE) || (state == ST_POST));
  assign rd_en    = (state == ST_FETCH);
  assign tx_valid = (state == ST_SEND);
  assign step_dn  = tx_valid && tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      cnt   <= '0;
      dly_q <= '0;
      rdn_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (arm) begin
            state <= ST_PRE;
            done  <= 1'b0;
            cnt   <= '0;
            dly_q <= delay_count;
            rdn_q <= read_count;
          end
        end
        ST_PRE: begin
          if (trig) begin
            cnt <= '0;
            if (dly_q == '0) begin
              if (rdn_q == '0) begin
                state <= ST_IDLE;
                done  <= 1'b1;
              end else begin
                state <= ST_FETCH;
              end
            end else begin
              state <= ST_POST;
            end
          end
        end
        ST_POST: begin
          if (smp_en) begin
            if (cnt_nxt == dly_q) begin
              cnt <= '0;
              if (rdn_q == '0) begin
                state <= ST_IDLE;
                done  <= 1'b1;
              end else begin
                state <= ST_FETCH;
              end
            end else begin
              cnt <= cnt_nxt;
            end
          end
        end
        ST_FETCH: state <= ST_SEND;
        ST_SEND: begin
          if (tx_ready) begin
            if (cnt_nxt == rdn_q) begin
              state <= ST_IDLE;
              done  <= 1'b1;
              cnt   <= '0;
            end else begin
              cnt   <= cnt_nxt;
              state <= ST_FETCH;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/capture_readback.sv
module capture_readback
  import cap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256,
  parameter int CNT_W  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              trig,
  input  logic              smp_en,
  input  logic [DATA_W-1:0] smp_data,
  input  logic [CNT_W-1:0]  delay_count,
  input  logic [CNT_W-1:0]  read_count,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              done
);
  cap_state_t    state;
  logic          clr_ptr, wr_en, rd_en, step_dn, busy;
  logic [AW-1:0] ptr, rd_addr;

  assign busy    = (state != ST_IDLE);
  // The pointer names the next free slot; read-out looks one below it.
  assign rd_addr = ptr - 1'b1;

  cap_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .arm(arm), .trig(trig), .smp_en(smp_en),
    .delay_count(delay_count), .read_count(read_count), .tx_ready(tx_ready),
    .state(state), .clr_ptr(clr_ptr), .wr_en(wr_en), .rd_en(rd_en),
    .step_dn(step_dn), .tx_valid(tx_valid), .done(done)
  );

  cap_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clr(clr_ptr), .up(wr_en), .down(step_dn),
    .ptr(ptr)
  );

  cap_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(wr_en), .waddr(ptr), .wdata(smp_data),
    .re(rd_en), .raddr(rd_addr), .rdata(tx_data)
  );
endmodule

// File: rtl/capture_readback_chk.sv
module capture_readback_chk #(
  parameter int DATA_W = 8,
  parameter int AW     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arm,
  input logic              busy,
  input logic              wr_en,
  input logic [AW-1:0]     ptr,
  input logic [DATA_W-1:0] tx_data,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              done
);
  a_r7_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  a_r7_bubble_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_valid);

  a_r5_no_store_in_readout: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !wr_en);

  a_r3_ptr_advances: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ptr == AW'($past(ptr) + 1'b1));

  a_r6_ptr_retreats: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> ptr == AW'($past(ptr) - 1'b1));

  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !tx_valid && !busy);

  a_r2_arm_starts: assert property (@(posedge clk) disable iff (!rst_n)
    arm && !busy |=> busy && !done);

  a_r2_arm_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    arm && busy && !wr_en && !(tx_valid && tx_ready) |=> $stable(ptr));
endmodule

bind capture_readback capture_readback_chk #(.DATA_W(DATA_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .busy(busy), .wr_en(wr_en),
  .ptr(ptr), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .done(done)
);

// File: tb/capture_readback_test.sv
module capture_readback_test;
  localparam int DW = 8;
  localparam int DP = 16;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0, trig = 1'b0, smp_en = 1'b0, tx_ready = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic [CW-1:0] delay_count = '0, read_count = '0;
  logic [DW-1:0] tx_data;
  logic tx_valid, done;

  int checks = 0, fails = 0, cyc = 0;
  logic [DW-1:0] bmem [DP];
  int bwp = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  capture_readback #(.DATA_W(DW), .DEPTH(DP), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .trig(trig), .smp_en(smp_en),
    .smp_data(smp_data), .delay_count(delay_count), .read_count(read_count),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .done(done)
  );

  // Fields: pre, delay, read, seed, stall, junk
  localparam int NV = 6;
  localparam logic [33:0] VEC [NV] = '{
    {8'd5,  8'd3,  8'd8,  8'h10, 1'b0, 1'b0},
    {8'd4,  8'd0,  8'd4,  8'h40, 1'b1, 1'b1},
    {8'd20, 8'd6,  8'd16, 8'h80, 1'b1, 1'b0},
    {8'd3,  8'd2,  8'd0,  8'hA0, 1'b0, 1'b0},
    {8'd0,  8'd5,  8'd3,  8'hC0, 1'b0, 1'b1},
    {8'd10, 8'd10, 8'd20, 8'hE3, 1'b1, 1'b1}
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_arm(input int dly, input int rd);
    delay_count = CW'(dly);
    read_count  = CW'(rd);
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    bwp = 0;
  endtask

  task automatic push(input logic [DW-1:0] d);
    smp_en = 1'b1;
    smp_data = d;
    bmem[bwp] = d;
    bwp = (bwp + 1) % DP;
    @(negedge clk);
    smp_en = 1'b0;
  endtask

  task automatic pulse_trig();
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  // Collect the read-out, comparing against the bench model.
  task automatic collect(input int rd, input logic stall, input logic junk, input string tag);
    int got = 0;
    int guard = 0;
    logic last = (rd == 0);
    smp_en = junk;
    smp_data = 8'h5A;
    while (!done && guard < 2000) begin
      tx_ready = stall ? ((guard % 3) != 0) : 1'b1;
      #1;
      if (tx_valid && tx_ready) begin
        int idx = ((bwp - 1 - got) % DP + DP) % DP;
        chk(tx_data == bmem[idx], {tag, " R6 order"}, tx_data, bmem[idx]);
        got++;
        if (got == rd) last = 1'b1;
      end
      guard++;
      @(negedge clk);
      if (last && got == rd && rd != 0) begin
        chk(done == 1'b1, {tag, " R9 done after last accept"}, done, 1);
        last = 1'b0;
      end
    end
    smp_en = 1'b0;
    tx_ready = 1'b0;
    chk(got == rd, {tag, " R8 sample count"}, got, rd);
    chk(done && !tx_valid, {tag, " R9 done idle"}, done, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog: cycles %0d expected below %0d", cyc, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < DP; i++) bmem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!tx_valid, "R1 tx_valid in reset", tx_valid, 0);
    chk(!done, "R1 done in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R5: strobes and trigger in idle are ignored
    pulse_trig();
    push(8'h77);
    chk(!done && !tx_valid, "R5 idle ignores input", tx_valid, 0);

    for (int v = 0; v < NV; v++) begin
      int pre = int'(VEC[v][33:26]);
      int dly = int'(VEC[v][25:18]);
      int rd  = int'(VEC[v][17:10]);
      logic [7:0] seed = VEC[v][9:2];
      do_arm(dly, rd);
      chk(!done, "R2 done cleared by arm", done, 0);
      for (int i = 0; i < pre; i++) push(seed + 8'(i));
      pulse_trig();
      for (int i = 0; i < dly; i++) begin
        chk(!tx_valid && !done, "R4 still capturing", tx_valid, 0);
        push(seed + 8'(pre + i));
      end
      collect(rd, VEC[v][1], VEC[v][0], $sformatf("vec%0d R3 R4 R5", v));
    end

    // R10: counts latched at arm
    do_arm(2, 2);
    delay_count = 16'd9;
    read_count  = 16'd9;
    for (int i = 0; i < 3; i++) push(8'h30 + 8'(i));
    pulse_trig();
    push(8'h33);
    push(8'h34);
    collect(2, 1'b0, 1'b0, "R10 latched counts");

    // R2: re-arm during capture ignored
    do_arm(0, 5);
    for (int i = 0; i < 3; i++) push(8'h60 + 8'(i));
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    for (int i = 3; i < 5; i++) push(8'h60 + 8'(i));
    pulse_trig();
    collect(5, 1'b0, 1'b0, "R2 arm while busy");

    // R4: trigger together with a sample, zero delay
    do_arm(0, 2);
    push(8'h91);
    smp_en = 1'b1;
    smp_data = 8'h92;
    bmem[bwp] = 8'h92;
    bwp = (bwp + 1) % DP;
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    smp_en = 1'b0;
    collect(2, 1'b0, 1'b0, "R4 trigger with sample");

    // R7: long stall holds data
    do_arm(1, 1);
    push(8'hB1);
    pulse_trig();
    push(8'hB2);
    @(negedge clk);
    chk(tx_valid && tx_data == 8'hB2, "R7 offered", tx_data, 8'hB2);
    repeat (4) @(negedge clk);
    chk(tx_valid && tx_data == 8'hB2, "R7 held under stall", tx_data, 8'hB2);
    collect(1, 1'b0, 1'b0, "R7 release");

    // R1: reset mid read-out, then capture from address 0
    do_arm(0, 3);
    push(8'hC1);
    pulse_trig();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!tx_valid && !done, "R1 reset mid read", tx_valid, 0);
    rst_n = 1'b1;
    do_arm(0, 1);
    push(8'hD4);
    pulse_trig();
    collect(1, 1'b0, 1'b0, "R1 restart");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule